// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins through an 8-bit register port. A single bank-select input decides whether a register access reaches the low eight pins or the high eight pins. Each pin holds five configuration bits: direction, output level, high-impedance request, interrupt enable and edge polarity.

Input pads pass through a two-stage synchronizer. The controller then compares each synchronized level with its value one cycle earlier to find edges. A qualifying edge on an enabled input pin sets a sticky status bit. The interrupt output is high while any status bit in either bank is set. Software reads the status register of a bank to learn which pins fired. That read clears exactly the bits it returned.

The polarity bit has two jobs. It picks the rising or the falling edge as the interrupting one, and it also decides whether a level read returns the pad state as it is or inverted.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A register access with `bank_sel` = 0 reaches pins 7:0, and one with `bank_sel` = 1 reaches pins 15:8. Register bit k maps to pin 8*bank_sel + k.
- R2: After reset the direction register reads 0xFF in both banks, so every pin is an input. The high-impedance, interrupt-enable, polarity, level and status registers read 0x00. `pad_oe` is all zero and `irq` is low.
- R3: Register map: address 0 is the level register, 1 is direction (1 = input, 0 = output), 2 is high-impedance, 3 is interrupt enable, 4 is polarity and 5 is status. A pin whose direction bit is 0 and whose high-impedance bit is 0 has `pad_oe` = 1. Such a pin drives the value last written to its level register on `pad_out`.
- R4: A pin with high-impedance bit 1 has `pad_oe` = 0. A pin with direction bit 1 also has `pad_oe` = 0, whatever its high-impedance bit holds.
- R5: A read of address 0 returns the synchronized pad level XOR the polarity bit. A change on `pad_in` can be seen by a read strobe from the third rising clock edge after it.
- R6: With polarity 0, a LOW-to-HIGH transition of an enabled input pin sets its status bit. With polarity 1, a HIGH-to-LOW transition does so, and a transition the other way does not. The bit is set on the third rising edge after the pad change.
- R7: A pin whose interrupt-enable bit is 0 never sets its status bit. A pin whose direction bit is 0 never sets it either.
- R8: A status read returns the bank's status bits and clears exactly those bits. If an edge sets a bit on the same clock edge as the clearing read, that bit stays set.
- R9: `irq` is high exactly while any status bit of either bank is set. Reading one bank's status leaves the other bank's bits intact.
- R10: Read data is registered. `rd_data` takes the addressed value on the clock edge that samples `rd_en` and holds it until the next read. Addresses 6 and 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 16 | Pad input levels, asynchronous |
| bank_sel | input | 1 | Chooses pins 7:0 (0) or 15:8 (1) for register access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| pad_out | output | 16 | Pad output values from the level registers |
| pad_oe | output | 16 | Pad output enables |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt, OR of all status bits |

## Verification
Two functions can land on the same clock edge: a detected edge that sets a status bit, and a status read that clears the bank's bits. The bench sets up this collision on purpose. It raises a pin and then issues the status read so that the read strobe is sampled on the third rising edge after the pad change. That is exactly the edge where the new bit gets set. The bench passes the case when three things hold: the read returns only the older bit, `irq` stays high, and a second read returns the new bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        RA_LEVEL = 3'd0,
        RA_DIR   = 3'd1,
        RA_HIZ   = 3'd2,
        RA_IEN   = 3'd3,
        RA_POL   = 3'd4,
        RA_STAT  = 3'd5
    } gpio_reg_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] lvl_now,
    output logic [NPINS-1:0] lvl_prev
);

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            logic meta_q;
            logic sync_q;
            logic prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pad_in[i];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            assign lvl_now[i]  = sync_q;
            assign lvl_prev[i] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   bank_sel,
    output logic [NPINS-1:0]       dir_q,
    output logic [NPINS-1:0]       hiz_q,
    output logic [NPINS-1:0]       ien_q,
    output logic [NPINS-1:0]       pol_q,
    output logic [NPINS-1:0]       lvl_q
);

    localparam int NBANK = NPINS / DW;

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            logic hit;
            assign hit = wr_en && (int'(bank_sel) == b);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dir_q[b*DW +: DW] <= '1;
                    hiz_q[b*DW +: DW] <= '0;
                    ien_q[b*DW +: DW] <= '0;
                    pol_q[b*DW +: DW] <= '0;
                    lvl_q[b*DW +: DW] <= '0;
                end else if (hit) begin
                    unique case (addr)
                        RA_LEVEL: lvl_q[b*DW +: DW] <= wdata;
                        RA_DIR:   dir_q[b*DW +: DW] <= wdata;
                        RA_HIZ:   hiz_q[b*DW +: DW] <= wdata;
                        RA_IEN:   ien_q[b*DW +: DW] <= wdata;
                        RA_POL:   pol_q[b*DW +: DW] <= wdata;
                        default:  ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NPINS = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_now,
    input  logic [NPINS-1:0] lvl_prev,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] ien_q,
    input  logic [NPINS-1:0] pol_q,
    input  logic             stat_rd,
    input  logic             bank_sel,
    output logic [NPINS-1:0] status_q,
    output logic             irq
);

    localparam int NBANK = NPINS / DW;

    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] clr_mask;

    genvar i, b;
    generate
        for (i = 0; i < NPINS; i++) begin : g_edge
            logic rise;
            logic fall;
            assign rise   = lvl_now[i] & ~lvl_prev[i];
            assign fall   = ~lvl_now[i] & lvl_prev[i];
            assign hit[i] = dir_q[i] & ien_q[i] & (pol_q[i] ? fall : rise);
        end
        for (b = 0; b < NBANK; b++) begin : g_clr
            assign clr_mask[b*DW +: DW] =
                {DW{stat_rd && (int'(bank_sel) == b)}};
        end
    endgenerate

    // A new edge wins over a clearing read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign irq = |status_q;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 8,
    parameter int AW    = GPIO_ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic             bank_sel,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [DW-1:0]    rd_data,
    output logic             irq
);

    logic [NPINS-1:0] lvl_now, lvl_prev;
    logic [NPINS-1:0] dir_q, hiz_q, ien_q, pol_q, lvl_q;
    logic [NPINS-1:0] status_q;
    logic [DW-1:0]    rd_next;
    logic             stat_rd;

    gpio_pin_sync #(.NPINS(NPINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    gpio_regfile #(.NPINS(NPINS), .DW(DW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .bank_sel (bank_sel),
        .dir_q    (dir_q),
        .hiz_q    (hiz_q),
        .ien_q    (ien_q),
        .pol_q    (pol_q),
        .lvl_q    (lvl_q)
    );

    assign stat_rd = rd_en && (addr == RA_STAT);

    gpio_edge_irq #(.NPINS(NPINS), .DW(DW)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev),
        .dir_q    (dir_q),
        .ien_q    (ien_q),
        .pol_q    (pol_q),
        .stat_rd  (stat_rd),
        .bank_sel (bank_sel),
        .status_q (status_q),
        .irq      (irq)
    );

    assign pad_out = lvl_q;
    assign pad_oe  = ~dir_q & ~hiz_q;

    always_comb begin
        int base;
        base = int'(bank_sel) * DW;
        unique case (addr)
            RA_LEVEL: rd_next = lvl_now[base +: DW] ^ pol_q[base +: DW];
            RA_DIR:   rd_next = dir_q[base +: DW];
            RA_HIZ:   rd_next = hiz_q[base +: DW];
            RA_IEN:   rd_next = ien_q[base +: DW];
            RA_POL:   rd_next = pol_q[base +: DW];
            RA_STAT:  rd_next = status_q[base +: DW];
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 16,
    parameter int DW    = 8,
    parameter int AW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic             bank_sel,
    input logic [DW-1:0]    rd_data,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] hiz_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] status_q
);

    // R2
    reset_all_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '1 && pad_oe == '0));

    // R4
    input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & dir_q) == '0) && ((pad_oe & hiz_q) == '0));

    // R7
    blocked_pin_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) & ~($past(ien_q) & $past(dir_q))) == '0);

    // R8
    stat_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(5) && !bank_sel) |=> rd_data == $past(status_q[DW-1:0]));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .bank_sel (bank_sel),
    .rd_data  (rd_data),
    .pad_oe   (pad_oe),
    .dir_q    (dir_q),
    .hiz_q    (hiz_q),
    .ien_q    (ien_q),
    .status_q (status_q)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad_in = '0;
    logic          bank_sel = 1'b0;
    logic [2:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [7:0]    rd_data;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     rd_fire = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .bank_sel (bank_sel),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    // monitor: the read strobe sampled at a rising edge yields rd_data after it
    always @(posedge clk) rd_fire <= rd_en;

    always @(negedge clk) begin
        if (rd_fire) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected read result act=%h exp=none", rd_data);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic b, input logic [7:0] d);
        @(negedge clk);
        addr = a; bank_sel = b; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic b, input logic [7:0] e,
                      input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        addr = a; bank_sel = b; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [NP-1:0] act, input logic [NP-1:0] exp,
                       input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        chk(pad_oe, 16'h0000, "R2 pad_oe after reset");
        chk({15'd0, irq}, 16'h0000, "R2 irq after reset");
        rd(3'd1, 1'b0, 8'hFF, "R2 dir bank0 reset");
        rd(3'd1, 1'b1, 8'hFF, "R2 dir bank1 reset");
        rd(3'd2, 1'b0, 8'h00, "R2 hiz reset");
        rd(3'd5, 1'b1, 8'h00, "R2 status reset");

        // R1 / R3 banked writes and output drive
        wr(3'd1, 1'b0, 8'hF0);
        wr(3'd0, 1'b0, 8'h05);
        wr(3'd1, 1'b1, 8'h7F);
        wr(3'd0, 1'b1, 8'h80);
        idle(1);
        chk(pad_oe, 16'h800F, "R3 pad_oe outputs");
        chk(pad_out, 16'h8005, "R3 pad_out level");
        rd(3'd1, 1'b0, 8'hF0, "R1 dir bank0");
        rd(3'd1, 1'b1, 8'h7F, "R1 dir bank1");

        // R4 high impedance
        wr(3'd2, 1'b0, 8'h03);
        wr(3'd2, 1'b1, 8'h01);
        idle(1);
        chk(pad_oe, 16'h800C, "R4 hiz and input pins off");
        rd(3'd2, 1'b1, 8'h01, "R4 hiz bank1 readback");

        // R5 level reads
        pad_in = 16'h1234;
        idle(3);
        rd(3'd0, 1'b0, 8'h34, "R5 level bank0");
        rd(3'd0, 1'b1, 8'h12, "R5 level bank1");
        wr(3'd4, 1'b1, 8'hFF);
        rd(3'd0, 1'b1, 8'hED, "R5 inverted level bank1");
        wr(3'd4, 1'b1, 8'h00);

        // R6 / R7 edge detection
        pad_in = 16'h0000;
        idle(4);
        wr(3'd3, 1'b0, 8'hFF);
        wr(3'd3, 1'b1, 8'hFF);
        wr(3'd4, 1'b0, 8'h20);
        pad_in = 16'h0031;
        idle(4);
        chk({15'd0, irq}, 16'h0001, "R6 irq after rising pin4");
        rd(3'd5, 1'b0, 8'h10, "R6 rise pol0 only, pin0 output R7");
        chk({15'd0, irq}, 16'h0000, "R8 irq cleared by read");
        pad_in = 16'h0011;
        idle(4);
        rd(3'd5, 1'b0, 8'h20, "R6 fall with pol1");
        wr(3'd3, 1'b1, 8'hFE);
        pad_in = 16'h8111;
        idle(4);
        chk({15'd0, irq}, 16'h0000, "R7 disabled or output pins");
        rd(3'd5, 1'b1, 8'h00, "R7 bank1 status empty");

        // R9 both banks
        pad_in = 16'h8351;
        idle(4);
        rd(3'd5, 1'b1, 8'h02, "R9 bank1 status");
        chk({15'd0, irq}, 16'h0001, "R9 bank0 bit keeps irq");
        rd(3'd5, 1'b0, 8'h40, "R9 bank0 status intact");
        chk({15'd0, irq}, 16'h0000, "R9 irq low when all clear");

        // R8 set and clear on the same edge
        wr(3'd4, 1'b0, 8'h30);
        pad_in = 16'h8341;
        idle(4);
        pad_in = 16'h83C1;
        idle(1);
        rd(3'd5, 1'b0, 8'h10, "R8 read returns older bit");
        chk({15'd0, irq}, 16'h0001, "R8 new bit survives clear");
        rd(3'd5, 1'b0, 8'h80, "R8 new bit read next");
        chk({15'd0, irq}, 16'h0000, "R8 irq after second read");

        // R10 unused addresses and hold
        wr(3'd6, 1'b0, 8'hAA);
        rd(3'd6, 1'b0, 8'h00, "R10 addr6 reads zero");
        rd(3'd1, 1'b0, 8'hF0, "R10 write to addr6 ignored");
        idle(3);
        chk({8'd0, rd_data}, 16'h00F0, "R10 rd_data held");

        idle(2);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 pending reads act=%0d exp=0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule